// File: doc/BRIEF.md
# Write-One-to-Modify GPIO Controller with Interrupts

The block drives and observes sixteen general-purpose pins from a simple register bus. Each pin has its own direction bit. Output levels can be written as a whole word, or changed through separate set, clear and toggle registers. In those three registers, only the bits written as 1 act, so software can change any group of pins in one write and leave the rest alone. A status read returns the present level of every pin: the driven value for outputs and the synchronized level for inputs.

Each pin can also raise an interrupt. Enable bits are changed through a set register and a clear register, with the same write-one rule. A sensitivity bit makes a pin level-triggered or edge-triggered. For edge-triggered pins, a second bit chooses rising edges only or both edges. Input pins trigger from activity on the pad, and output pins trigger from software writes to their driven value. Edge events are held as pending until software clears them. All enabled sources are combined onto one interrupt request line.

Top module: `gpio_w1m`

## Requirements
- R1: After reset, every register is zero: `pin_oe`, `pin_out` and `irq` are 0, all pins are inputs, level-sensitive and masked.
- R2: A write to address 4 loads the direction register (1 = output) and appears on `pin_oe` on the next cycle. Reading address 4 returns it.
- R3: A write to address 1 drives high the output bits written as 1. Bits written as 0 keep their value. Reading address 1 returns the output register.
- R4: A write to address 2 drives low the output bits written as 1. Other bits keep their value.
- R5: A write to address 3 inverts the output bits written as 1. Other bits keep their value.
- R6: A write to address 0 replaces the whole output register with the written word.
- R7: Reading address 0 returns, per pin, the output register bit for output pins and the input level for input pins. An input change on `pin_in` becomes visible two clock edges later.
- R8: Writing 1s to address 5 sets interrupt enable bits, and writing 1s to address 6 clears them. Bits written as 0 are unchanged. Reading address 5 returns the enables.
- R9: A pin whose sensitivity bit (address 7) is 0 is level-sensitive. It contributes to `irq` for as long as its source is high and it is enabled.
- R10: A pin whose sensitivity bit is 1 and whose edge-select bit (address 8) is 0 sets its pending bit one cycle after its source rises. It ignores falling edges.
- R11: An edge-sensitive pin whose edge-select bit is 1 sets its pending bit on both rising and falling edges of its source.
- R12: Writing 1s to address 9 clears those pending bits. If a new edge arrives in the same cycle, the set wins. Reading address 9 returns the pending bits.
- R13: The interrupt source of an output pin is its output register bit, so set, clear, toggle and direct writes can trigger it.
- R14: `irq` is the OR, over all pins, of the enable bit ANDed with the pending bit (edge pins) or with the live source (level pins).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| pin_in | input | 16 | Pad input levels |
| pin_out | output | 16 | Pad output values |
| pin_oe | output | 16 | Pad output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The main function is tried with directed writes of alternating-bit patterns to each output register. These tell set, clear and toggle apart, because each one leaves a different result on bits written as 0 and bits written as 1. Input patterns are stepped across the pins in level, rising-only and both-edge modes. This separates a live-level contribution from a latched one, and separates a falling edge that is ignored from one that counts. Both input and output pins are used as interrupt sources, so the source selection by direction is exercised. A long random walk then mixes writes to every address with random pad activity. A per-cycle reference model compares every output and the read-back value on each clock, which exposes collisions such as a pending clear landing on a fresh edge.

// File: rtl/gpio_w1m.sv
module gpio_w1m #(
  parameter int NPIN = 16,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [NPIN-1:0] wdata,
  output logic [NPIN-1:0] rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq
);
  localparam logic [AW-1:0] A_DATA = AW'(0);
  localparam logic [AW-1:0] A_SET  = AW'(1);
  localparam logic [AW-1:0] A_CLR  = AW'(2);
  localparam logic [AW-1:0] A_TGL  = AW'(3);
  localparam logic [AW-1:0] A_DIR  = AW'(4);
  localparam logic [AW-1:0] A_MSET = AW'(5);
  localparam logic [AW-1:0] A_MCLR = AW'(6);
  localparam logic [AW-1:0] A_SENS = AW'(7);
  localparam logic [AW-1:0] A_BOTH = AW'(8);
  localparam logic [AW-1:0] A_PEND = AW'(9);

  logic [NPIN-1:0] out_q, dir_q, mask_q, sens_q, both_q, pend_q;
  logic [NPIN-1:0] sync1, sync2, src_q;
  logic [NPIN-1:0] src, rise, fall, evt, pclr, active;

  assign src    = (dir_q & out_q) | (~dir_q & sync2);
  assign rise   = src & ~src_q;
  assign fall   = ~src & src_q;
  assign evt    = sens_q & (rise | (both_q & fall));
  assign pclr   = (wr_en && addr == A_PEND) ? wdata : '0;
  assign active = mask_q & ((sens_q & pend_q) | (~sens_q & src));
  assign irq    = |active;
  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      src_q <= '0;
      pend_q <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      src_q <= src;
      pend_q <= (pend_q & ~pclr) | evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
      sens_q <= '0;
      both_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_DATA: out_q  <= wdata;
        A_SET:  out_q  <= out_q | wdata;
        A_CLR:  out_q  <= out_q & ~wdata;
        A_TGL:  out_q  <= out_q ^ wdata;
        A_DIR:  dir_q  <= wdata;
        A_MSET: mask_q <= mask_q | wdata;
        A_MCLR: mask_q <= mask_q & ~wdata;
        A_SENS: sens_q <= wdata;
        A_BOTH: both_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_DATA:  rdata = src;
      A_SET:   rdata = out_q;
      A_DIR:   rdata = dir_q;
      A_MSET:  rdata = mask_q;
      A_SENS:  rdata = sens_q;
      A_BOTH:  rdata = both_q;
      A_PEND:  rdata = pend_q;
      default: rdata = '0;
    endcase
  end

  a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SET) |=> ((pin_out & $past(wdata)) == $past(wdata)));
  a_r3_keep_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SET) |=> ((pin_out & ~$past(wdata)) == ($past(pin_out) & ~$past(wdata))));
  a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLR) |=> ((pin_out & $past(wdata)) == '0));
  a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_TGL) |=> (pin_out == ($past(pin_out) ^ $past(wdata))));
  a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DIR) |=> (pin_oe == $past(wdata)));
  a_r14_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
  a_r12_no_wr_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && evt == '0) |=> $stable(pend_q));
endmodule

// File: tb/sim_gpio_w1m.sv
module sim_gpio_w1m;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] addr = 0;
  logic [N-1:0] wdata = 0, pin_in = 0;
  logic [N-1:0] rdata, pin_out, pin_oe;
  logic irq;

  gpio_w1m u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
               .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  string tag = "R1";
  bit done = 0;

  bit m_out[N], m_dir[N], m_mask[N], m_sens[N], m_both[N], m_pend[N];
  bit h1[N], h2[N], m_prev[N];

  function automatic bit m_src(int i);
    return m_dir[i] ? m_out[i] : h2[i];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_out[i]=0; m_dir[i]=0; m_mask[i]=0; m_sens[i]=0; m_both[i]=0;
        m_pend[i]=0; h1[i]=0; h2[i]=0; m_prev[i]=0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        bit s, e;
        s = m_src(i);
        e = m_sens[i] && ((s && !m_prev[i]) || (m_both[i] && !s && m_prev[i]));
        if (wr_en && addr == 9 && wdata[i]) m_pend[i] = 0;
        if (e) m_pend[i] = 1;
        m_prev[i] = s;
        h2[i] = h1[i];
        h1[i] = pin_in[i];
        if (wr_en) begin
          case (addr)
            0: m_out[i] = wdata[i];
            1: if (wdata[i]) m_out[i] = 1;
            2: if (wdata[i]) m_out[i] = 0;
            3: if (wdata[i]) m_out[i] = !m_out[i];
            4: m_dir[i] = wdata[i];
            5: if (wdata[i]) m_mask[i] = 1;
            6: if (wdata[i]) m_mask[i] = 0;
            7: m_sens[i] = wdata[i];
            8: m_both[i] = wdata[i];
            default: ;
          endcase
        end
      end
    end
  end

  task automatic chk(string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      logic [N-1:0] e_out, e_oe, e_rd;
      bit e_irq;
      e_irq = 0;
      for (int i = 0; i < N; i++) begin
        e_out[i] = m_out[i];
        e_oe[i]  = m_dir[i];
        if (m_mask[i] && (m_sens[i] ? m_pend[i] : m_src(i))) e_irq = 1;
        case (addr)
          0: e_rd[i] = m_src(i);
          1: e_rd[i] = m_out[i];
          4: e_rd[i] = m_dir[i];
          5: e_rd[i] = m_mask[i];
          7: e_rd[i] = m_sens[i];
          8: e_rd[i] = m_both[i];
          9: e_rd[i] = m_pend[i];
          default: e_rd[i] = 0;
        endcase
      end
      chk("pin_out", pin_out, e_out);
      chk("pin_oe", pin_oe, e_oe);
      chk("irq", {15'b0, irq}, {15'b0, e_irq});
      chk("rdata", rdata, e_rd);
    end
  end

  task automatic wr(int a, logic [N-1:0] d);
    @(negedge clk); wr_en = 1; addr = 4'(a); wdata = d;
    @(negedge clk); wr_en = 0; wdata = 0;
  endtask

  task automatic rd(int a, int n);
    @(negedge clk); addr = 4'(a);
    repeat (n) @(negedge clk);
  endtask

  task automatic pins(logic [N-1:0] v, int a);
    @(negedge clk); pin_in = v; addr = 4'(a);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; rd(0, 2); rd(9, 2);
    tag = "R2"; wr(4, 16'h00FF); rd(4, 2);
    tag = "R6"; wr(0, 16'hA5A5); rd(1, 2);
    tag = "R3"; wr(1, 16'h0F0F); rd(1, 2);
    tag = "R4"; wr(2, 16'h5555); rd(1, 2);
    tag = "R5"; wr(3, 16'hFF00); rd(1, 2);
    tag = "R7"; pins(16'h3C3C, 0); pins(16'hC3C3, 0); pins(16'h0000, 0);
    tag = "R8"; wr(5, 16'hFFFF); wr(6, 16'h00F0); rd(5, 2);
    tag = "R9"; wr(0, 16'h0000); wr(7, 16'h0000); pins(16'h0100, 9); pins(16'h0000, 9);
    tag = "R10"; wr(7, 16'hFF00); wr(8, 16'h0000);
    pins(16'h0200, 9); pins(16'h0000, 9);
    tag = "R12"; wr(9, 16'hFFFF); rd(9, 2);
    tag = "R11"; wr(8, 16'hFF00); pins(16'h0400, 9); wr(9, 16'hFFFF); pins(16'h0000, 9);
    wr(9, 16'hFFFF);
    tag = "R13"; wr(7, 16'hFFFF); wr(8, 16'h000F); wr(3, 16'h0003); rd(9, 2);
    wr(3, 16'h0003); rd(9, 2); wr(9, 16'hFFFF); wr(1, 16'h0004); rd(0, 2);
    tag = "R14";
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      pin_in = 16'($urandom);
      addr = 4'($urandom_range(0, 10));
      wr_en = ($urandom_range(0, 2) == 0);
      wdata = 16'($urandom);
      if (addr == 6 && $urandom_range(0, 3) != 0) wr_en = 0;
    end
    @(negedge clk); wr_en = 0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule